// File: doc/BRIEF.md
# Normal-Basis Finite-Field Multiplier

This block multiplies two elements of the binary extension field GF(2^K). Each element is a K-bit vector over a normal basis: bit i holds the coefficient of the primitive root raised to the power 2^i. In this basis the all-ones vector is the multiplicative identity, addition is bitwise XOR, and squaring an element is a one-place cyclic rotation. K is a parameter. K = 6 uses the field polynomial x^6 + x^5 + 1, and K = 3 uses x^3 + x^2 + 1.

The product is formed in three steps. A coder turns each nonzero operand into its discrete logarithm to the primitive root. An adder sums the two logarithms modulo 2^K − 1. A decoder turns the sum back into a vector. Both lookup tables are computed at elaboration from the polynomial arithmetic of the chosen field, so no table is written out by hand. A zero operand skips the tables and yields zero. The result is registered, so each accepted operand pair appears one clock later with its own valid strobe.

Top module: `gfnb_mul`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `out_prod` are both 0 after that edge.
- R2: `out_valid` equals the value of `in_valid` at the previous rising edge.
- R3: If either operand is the all-zero vector when `in_valid` is high, the product is the all-zero vector.
- R4: The all-ones vector is the identity: a product with an all-ones operand equals the other operand.
- R5: A product of an operand with itself is that operand rotated by one place: result bit i equals operand bit i−1, and result bit 0 equals operand bit K−1.
- R6: For nonzero operands root^m and root^n, the product is root^((m+n) mod (2^K − 1)). It is never zero.
- R7: The root is the vector with only bit 0 set. For K = 6, repeated multiplication by the root gives these powers: 5 → 6'h34, 9 → 6'h2D, 21 → 6'h2A, 31 → 6'h18, 45 → 6'h09, 62 → 6'h30. For K = 3 it gives: 3 → 3'h5, 5 → 3'h6, 6 → 3'h3, 7 → 3'h7.
- R8: While `in_valid` is low, `out_prod` keeps its previous value, whatever the operand inputs do.
- R9: The exponent sum wraps modulo 2^K − 1, so a sum that reaches or passes 2^K − 1 selects the reduced power. The sum fed to the decoder is always below 2^K − 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The operand pair on `in_a`/`in_b` is to be multiplied |
| in_a | input | K | First operand, normal-basis coordinates |
| in_b | input | K | Second operand, normal-basis coordinates |
| out_valid | output | 1 | `out_prod` holds a product produced this cycle |
| out_prod | output | K | Registered product, normal-basis coordinates |

## Verification
The assertions assume the operand inputs are settled at each rising edge whenever `in_valid` is high. They also assume the identity and squaring checks are judged against the operands sampled at the same edge that produced the product. The stimulus changes inputs only one nanosecond after a rising edge, and holds them for the whole cycle. Operand values range over the full K-bit space, zero included, so the zero bypass and the exponent wraparound are reached both in directed cases and in the random stream.

// File: rtl/gfnb_pkg.sv
package gfnb_pkg;

  localparam int MAXK = 6;
  localparam int MAXN = 1 << MAXK;

  typedef logic [MAXN-1:0][MAXK-1:0] gf_tbl_t;
  typedef logic [MAXK:0] gf_poly_t;

  // Low-order coefficients of the field polynomial (the x^k term is implied).
  function automatic int field_poly(int k);
    case (k)
      3:       return 5;   // x^3 + x^2 + 1
      6:       return 33;  // x^6 + x^5 + 1
      default: return 0;
    endcase
  endfunction

  // Multiply a polynomial-basis value by x, reducing modulo the field polynomial.
  function automatic gf_poly_t poly_mulx(gf_poly_t p, int k, int f);
    gf_poly_t r;
    r = p << 1;
    if (r[k]) begin
      r[k] = 1'b0;
      r = r ^ gf_poly_t'(f);
    end
    return r;
  endfunction

  function automatic gf_poly_t poly_mul(gf_poly_t a, gf_poly_t b, int k, int f);
    gf_poly_t r;
    gf_poly_t x;
    r = '0;
    x = a;
    for (int i = 0; i < MAXK; i++) begin
      if (i < k && b[i]) r = r ^ x;
      x = poly_mulx(x, k, f);
    end
    return r;
  endfunction

  // Entry n is root^n in normal-basis coordinates, for n in 0 .. 2^k-2.
  function automatic gf_tbl_t build_antilog(int k, int f);
    gf_tbl_t tbl;
    gf_tbl_t poly_to_norm;
    logic [MAXK-1:0][MAXK:0] conj;
    gf_poly_t acc;
    gf_poly_t p;
    tbl = '0;
    poly_to_norm = '0;
    conj = '0;
    conj[0] = gf_poly_t'(2);
    for (int i = 1; i < k; i++) conj[i] = poly_mul(conj[i-1], conj[i-1], k, f);
    for (int v = 0; v < (1 << k); v++) begin
      acc = '0;
      for (int i = 0; i < k; i++) if (((v >> i) & 1) != 0) acc = acc ^ conj[i];
      poly_to_norm[acc[MAXK-1:0]] = MAXK'(v);
    end
    p = gf_poly_t'(1);
    for (int n = 0; n < (1 << k) - 1; n++) begin
      tbl[n] = poly_to_norm[p[MAXK-1:0]];
      p = poly_mulx(p, k, f);
    end
    return tbl;
  endfunction

  // Entry v is the discrete log of nonzero element v; entry 0 is unused.
  function automatic gf_tbl_t build_log(int k, int f);
    gf_tbl_t al;
    gf_tbl_t lg;
    al = build_antilog(k, f);
    lg = '0;
    for (int n = 0; n < (1 << k) - 1; n++) lg[al[n]] = MAXK'(n);
    return lg;
  endfunction

endpackage

// File: rtl/gfnb_coder.sv
module gfnb_coder #(
  parameter int K = 6
) (
  input  logic [K-1:0] elem,
  output logic         is_zero,
  output logic [K-1:0] expo
);
  import gfnb_pkg::*;

  localparam gf_tbl_t LOG_TBL = build_log(K, field_poly(K));

  logic [MAXK-1:0] idx;

  assign idx     = MAXK'(elem);
  assign is_zero = (elem == '0);
  assign expo    = LOG_TBL[idx][K-1:0];
endmodule

// File: rtl/gfnb_expadd.sv
module gfnb_expadd #(
  parameter int K = 6
) (
  input  logic [K-1:0] ea,
  input  logic [K-1:0] eb,
  output logic [K-1:0] sum
);
  localparam int ORDER = (1 << K) - 1;

  logic [K:0] raw;
  logic [K:0] reduced;

  assign raw     = {1'b0, ea} + {1'b0, eb};
  assign reduced = (raw >= (K+1)'(ORDER)) ? raw - (K+1)'(ORDER) : raw;
  assign sum     = reduced[K-1:0];
endmodule

// File: rtl/gfnb_decoder.sv
module gfnb_decoder #(
  parameter int K = 6
) (
  input  logic [K-1:0] expo,
  output logic [K-1:0] elem
);
  import gfnb_pkg::*;

  localparam gf_tbl_t ALOG_TBL = build_antilog(K, field_poly(K));

  logic [MAXK-1:0] idx;

  assign idx  = MAXK'(expo);
  assign elem = ALOG_TBL[idx][K-1:0];
endmodule

// File: rtl/gfnb_mul.sv
module gfnb_mul #(
  parameter int K = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [K-1:0] in_a,
  input  logic [K-1:0] in_b,
  output logic         out_valid,
  output logic [K-1:0] out_prod
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][K-1:0] operand;
  logic [NOPS-1:0][K-1:0] opexp;
  logic [NOPS-1:0]        opzero;

  // Internal events brought out by name for the checker.
  logic         a_zero;
  logic         b_zero;
  logic [K-1:0] exp_sum;
  logic [K-1:0] dec_elem;
  logic [K-1:0] prod_next;

  assign operand[0] = in_a;
  assign operand[1] = in_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_coder
    gfnb_coder #(.K(K)) u_coder (
      .elem    (operand[g]),
      .is_zero (opzero[g]),
      .expo    (opexp[g])
    );
  end

  assign a_zero = opzero[0];
  assign b_zero = opzero[1];

  gfnb_expadd #(.K(K)) u_add (
    .ea  (opexp[0]),
    .eb  (opexp[1]),
    .sum (exp_sum)
  );

  gfnb_decoder #(.K(K)) u_dec (
    .expo (exp_sum),
    .elem (dec_elem)
  );

  assign prod_next = (a_zero || b_zero) ? '0 : dec_elem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_prod <= prod_next;
    end
  end
endmodule

// File: rtl/gfnb_mul_chk.sv
module gfnb_mul_chk #(
  parameter int K = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [K-1:0] in_a,
  input logic [K-1:0] in_b,
  input logic         out_valid,
  input logic [K-1:0] out_prod,
  input logic         a_zero,
  input logic         b_zero,
  input logic [K-1:0] exp_sum
);
  localparam int ORDER = (1 << K) - 1;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_prod == '0)); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid))); // R2

  AST_ZERO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_zero || b_zero)) |=> (out_prod == '0)); // R3

  AST_ONES_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_b == {K{1'b1}}) |=> (out_prod == $past(in_a))); // R4

  AST_SQUARE_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_a == in_b) |=> (out_prod == {$past(in_a[K-2:0]), $past(in_a[K-1])})); // R5

  AST_NO_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_a != '0 && in_b != '0) |=> (out_prod != '0)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_prod)); // R8

  AST_EXP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !a_zero && !b_zero) |-> (int'(exp_sum) < ORDER)); // R9
endmodule

bind gfnb_mul gfnb_mul_chk #(.K(K)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_prod  (out_prod),
  .a_zero    (a_zero),
  .b_zero    (b_zero),
  .exp_sum   (exp_sum)
);

// File: tb/sim_gfnb_mul.sv
`timescale 1ns/1ps
module sim_gfnb_mul;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       vld;
  logic [5:0] a6, b6, p6;
  logic [2:0] a3, b3, p3;
  logic       ov6, ov3;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cmp_on = 1'b0;

  // pw[s][n]: power n of the root; s=0 for K=6, s=1 for K=3
  int pw [2][64];

  logic       ev6, ev3;
  logic [5:0] ep6;
  logic [2:0] ep3;

  always #2.5 clk = ~clk;

  gfnb_mul #(.K(6)) u0 (.clk(clk), .rst_n(rst_n), .in_valid(vld), .in_a(a6), .in_b(b6),
                        .out_valid(ov6), .out_prod(p6));
  gfnb_mul #(.K(3)) u1 (.clk(clk), .rst_n(rst_n), .in_valid(vld), .in_a(a3), .in_b(b3),
                        .out_valid(ov3), .out_prod(p3));

  function automatic int rot(int v, int k);
    return ((v << 1) | (v >> (k - 1))) & ((1 << k) - 1);
  endfunction

  function automatic int ref_mul(int s, int k, int x, int y);
    int n, lx, ly;
    n = (1 << k) - 1;
    if (x == 0 || y == 0) return 0;
    lx = 0; ly = 0;
    for (int i = 0; i < n; i++) begin
      if (pw[s][i] == x) lx = i;
      if (pw[s][i] == y) ly = i;
    end
    return pw[s][(lx + ly) % n];
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Derive the power sequence from the recurrence of the field polynomial,
  // searching the seeds that are not powers of two until squaring is a rotation.
  task automatic build(int s, int k, int f);
    int p [64];
    int unk [6];
    int u, n, mask, found;
    bit ok;
    n = (1 << k) - 1;
    mask = n;
    u = 0;
    found = 0;
    for (int j = 1; j < k; j++) if ((j & (j - 1)) != 0) begin unk[u] = j; u++; end
    for (int cand = 0; cand < (1 << (u * k)) && found == 0; cand++) begin
      p[0] = mask;
      for (int i = 0; i < k; i++) if ((1 << i) < k) p[1 << i] = 1 << i;
      for (int q = 0; q < u; q++) p[unk[q]] = (cand >> (q * k)) & mask;
      for (int m = k; m <= n; m++) begin
        p[m] = 0;
        for (int j = 0; j < k; j++) if (((f >> j) & 1) != 0) p[m] = p[m] ^ p[m - k + j];
      end
      ok = (p[n] == mask);
      for (int m = 0; m < n; m++) begin
        if (p[m] == 0) ok = 1'b0;
        if (p[(2 * m) % n] != rot(p[m], k)) ok = 1'b0;
      end
      if (ok) begin
        found = 1;
        for (int m = 0; m < n; m++) pw[s][m] = p[m];
      end
    end
    chk("R6 power table derivable", found, 1);
  endtask

  // Cycle-by-cycle reference model.
  always @(posedge clk) begin
    if (!rst_n) begin
      ev6 = 1'b0; ep6 = '0; ev3 = 1'b0; ep3 = '0;
    end else begin
      ev6 = vld; ev3 = vld;
      if (vld) begin
        ep6 = 6'(ref_mul(0, 6, int'(a6), int'(b6)));
        ep3 = 3'(ref_mul(1, 3, int'(a3), int'(b3)));
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R2 u0 valid", int'(ov6), int'(ev6));
      chk("R6 u0 product", int'(p6), int'(ep6));
      chk("R2 u1 valid", int'(ov3), int'(ev3));
      chk("R6 u1 product", int'(p3), int'(ep3));
    end
  end

  task automatic mul_once(int x6, int y6, int x3, int y3, output int r6, output int r3);
    @(posedge clk); #1;
    vld = 1'b1; a6 = 6'(x6); b6 = 6'(y6); a3 = 3'(x3); b3 = 3'(y3);
    @(posedge clk); #1;
    vld = 1'b0;
    @(negedge clk);
    r6 = int'(p6); r3 = int'(p3);
  endtask

  initial begin
    int r6, r3, q6, q3;
    int alist [4];
    rst_n = 1'b0; vld = 1'b0; a6 = '0; b6 = '0; a3 = '0; b3 = '0;
    build(0, 6, 33);
    build(1, 3, 5);
    chk("R7 table 5", pw[0][5], 'h34);
    chk("R7 table 45", pw[0][45], 'h09);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 u0 valid", int'(ov6), 0);
    chk("R1 u0 prod", int'(p6), 0);
    chk("R1 u1 valid", int'(ov3), 0);
    chk("R1 u1 prod", int'(p3), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R7: powers by repeated multiplication by the root
    r6 = 1; r3 = 1;
    for (int n = 1; n < 63; n++) begin
      mul_once(r6, 1, r3, 1, r6, r3);
      chk("R7 u0 chain", r6, pw[0][(n + 1) % 63]);
      chk("R7 u1 chain", r3, pw[1][(n + 1) % 7]);
      case (n + 1)
        5:  chk("R7 u0 power 5", r6, 'h34);
        9:  chk("R7 u0 power 9", r6, 'h2D);
        21: chk("R7 u0 power 21", r6, 'h2A);
        31: chk("R7 u0 power 31", r6, 'h18);
        45: chk("R7 u0 power 45", r6, 'h09);
        62: chk("R7 u0 power 62", r6, 'h30);
        default: ;
      endcase
      case (n + 1)
        3: chk("R7 u1 power 3", r3, 'h5);
        5: chk("R7 u1 power 5", r3, 'h6);
        6: chk("R7 u1 power 6", r3, 'h3);
        7: chk("R7 u1 power 7", r3, 'h7);
        default: ;
      endcase
    end

    // R3: zero operands
    mul_once(0, 'h2D, 0, 5, r6, r3);
    chk("R3 u0 zero a", r6, 0); chk("R3 u1 zero a", r3, 0);
    mul_once('h2D, 0, 5, 0, r6, r3);
    chk("R3 u0 zero b", r6, 0); chk("R3 u1 zero b", r3, 0);
    mul_once(0, 0, 0, 0, r6, r3);
    chk("R3 u0 zero both", r6, 0); chk("R3 u1 zero both", r3, 0);

    // R4: all-ones identity
    alist[0] = 1; alist[1] = 'h34; alist[2] = 'h3F; alist[3] = 'h2A;
    for (int i = 0; i < 4; i++) begin
      mul_once(alist[i], 'h3F, alist[i] & 7, 7, r6, r3);
      chk("R4 u0 identity right", r6, alist[i]);
      chk("R4 u1 identity right", r3, alist[i] & 7);
      mul_once('h3F, alist[i], 7, alist[i] & 7, r6, r3);
      chk("R4 u0 identity left", r6, alist[i]);
      chk("R4 u1 identity left", r3, alist[i] & 7);
    end

    // R5: squaring is a rotation
    for (int v = 0; v < 64; v++) begin
      mul_once(v, v, v & 7, v & 7, r6, r3);
      chk("R5 u0 square", r6, rot(v, 6));
      chk("R5 u1 square", r3, rot(v & 7, 3));
    end

    // R9: exponent wraparound
    mul_once(pw[0][40], pw[0][40], pw[1][4], pw[1][4], r6, r3);
    chk("R9 u0 wrap 80", r6, pw[0][17]); chk("R9 u1 wrap 8", r3, pw[1][1]);
    mul_once(pw[0][62], pw[0][1], pw[1][6], pw[1][1], r6, r3);
    chk("R9 u0 wrap to one", r6, 63); chk("R9 u1 wrap to one", r3, 7);
    mul_once(pw[0][62], pw[0][62], pw[1][6], pw[1][6], r6, r3);
    chk("R9 u0 wrap max", r6, pw[0][61]); chk("R9 u1 wrap max", r3, pw[1][5]);

    // R8: product holds while in_valid is low
    mul_once('h34, 'h2D, 5, 6, q6, q3);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      a6 = 6'($urandom); b6 = 6'($urandom); a3 = 3'($urandom); b3 = 3'($urandom);
      @(negedge clk);
      chk("R8 u0 hold", int'(p6), q6);
      chk("R8 u1 hold", int'(p3), q3);
    end

    // R2/R6: random stream against the model
    repeat (400) begin
      @(posedge clk); #1;
      vld = 1'($urandom);
      a6 = 6'($urandom); b6 = 6'($urandom); a3 = 3'($urandom); b3 = 3'($urandom);
    end
    @(posedge clk); #1;
    vld = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule